// File: doc/BRIEF.md
# Bus Mode Detector with Reconfiguration Request

This block sits beside the bus interface of a card whose logic image supports only one bus mode. While the host holds the bus in reset, it drives an initialization pattern on a few bus lines. That pattern tells every card which mode the bus will run in once reset ends. The detector captures the pattern and decodes it into a two-bit mode. It then compares that mode with the one mode the loaded image can serve. On a mismatch it raises a reconfiguration request, which an external loader may act on.

While the request is raised, the detector also holds the device-side logic in its local reset. The card therefore stays invisible on the bus instead of answering in a mode it cannot handle. The detector itself keeps running. A later bus reset that carries a supported pattern clears the request and releases the device logic, with no power cycle needed.

The capture stays open for as long as both the bus reset and the synchronized user reset are active, so the request output follows transient pattern changes during that window. When the user reset is released, the capture closes. One clock later a valid flag rises, and from that point consumers may act on the request. Configuration forcing inputs can override the build-time supported mode.

Top module: `bmd_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `lrst_o` is 1; after `rst`, `det_mode_o` reads 00 and `vld_o` reads 0.
- R2: `usr_rst_i` passes through a two-flop synchronizer to the local clock. `usr_rst_i` is driven low so that the first rising edge to sample it low is edge 1. `vld_o` then stays 0 through edge 2 and rises at edge 3.
- R3: The pattern lines `pat_i[2:0]` decode as follows. With bit 2 at 0, the mode is conventional (00). With bit 2 at 1, bits 1:0 of 01 give PCI-X 66 (01) and bits 1:0 of 10 give PCI-X 133 (10). Bits 1:0 of 00 or 11 are reserved and decode as conventional (00). `det_mode_o` never reads 11.
- R4: When `frc_en_i` is 0, the supported mode is the parameter `SUPPORTED` (default 10). When `frc_en_i` is 1, the supported mode is `frc_mode_i`, with 11 read as conventional (00).
- R5: `rtr_o` is 1 exactly when `det_mode_o` differs from the supported mode. While both `bus_rst_i` and the synchronized user reset are high, a pattern change shows on `det_mode_o` and `rtr_o` after the next rising edge.
- R6: When `bus_rst_i` is low or the synchronized user reset is low, changes on `pat_i` leave `det_mode_o` unchanged.
- R7: `lrst_o` is 1 whenever any of these holds: `rst` is high, the synchronized user reset is high, or `rtr_o` is 1. Otherwise `lrst_o` is 0.
- R8: After a capture that set `rtr_o`, a later bus reset carrying a supported pattern clears `rtr_o` and drops `lrst_o` to 0, without `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high power-on reset of the detector |
| bus_rst_i | input | 1 | Bus reset, active high; the pattern is valid while it is high |
| usr_rst_i | input | 1 | User-side reset, active high, asynchronous to `clk` |
| pat_i | input | 3 | Bus-mode initialization pattern lines |
| frc_en_i | input | 1 | Enables the forced supported mode |
| frc_mode_i | input | 2 | Forced supported mode (00 conventional, 01 X66, 10 X133, 11 as 00) |
| det_mode_o | output | 2 | Captured bus mode |
| rtr_o | output | 1 | Reconfiguration request: detected mode differs from the supported mode |
| vld_o | output | 1 | Capture closed and `rtr_o` is settled |
| lrst_o | output | 1 | Gated reset for the device-side logic |

## Verification
All eight pattern codes are swept against every forcing setting, and against the build default. Each code has to land on its own decoded mode, reserved codes included. The sweep sets a supported mode equal to that decoded mode and then different from it, which separates a correct compare from a stuck request. During each open window the top pattern bit is toggled, to show that the request follows transients one edge later. After the window closes, the pattern is inverted, to show that it is ignored both when the bus reset is low and when the user reset is still high on its own. Valid-flag timing is checked edge by edge, and a mismatch followed by a matching bus reset shows that the request clears without a power-on reset.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

    localparam int PAT_W = 3;

    typedef enum logic [1:0] {
        MODE_CONV = 2'b00,
        MODE_X66  = 2'b01,
        MODE_X133 = 2'b10,
        MODE_RSVD = 2'b11
    } bus_mode_e;

    typedef struct packed {
        bus_mode_e mode;
        logic      valid;
    } capture_t;

    // Pattern decode; reserved codes fall back to conventional.
    function automatic bus_mode_e decode_pattern(input logic [PAT_W-1:0] pat);
        bus_mode_e m;
        m = MODE_CONV;
        if (pat[2]) begin
            case (pat[1:0])
                2'b01:   m = MODE_X66;
                2'b10:   m = MODE_X133;
                default: m = MODE_CONV;
            endcase
        end
        return m;
    endfunction

    // Supported mode after optional forcing; encoding 11 maps to conventional.
    function automatic bus_mode_e resolve_support(input logic       en,
                                                  input logic [1:0] forced,
                                                  input logic [1:0] built);
        logic [1:0] sel;
        sel = en ? forced : built;
        if (sel == 2'b11) return MODE_CONV;
        return bus_mode_e'(sel);
    endfunction

endpackage

// File: rtl/bmd_sync.sv
module bmd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

    // R2: the synchronized reset only rises after the raw input was high
    a_r2_no_early_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(q_o) |-> $past(d_i))
        else $error("a_r2_no_early_rise");

endmodule

// File: rtl/bmd_capture.sv
module bmd_capture
    import bmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_rst_i,
    input  logic             usr_sync_i,
    input  logic [PAT_W-1:0] pat_i,
    output capture_t         cap_o
);

    capture_t  cap_q;
    logic      open_w;
    bus_mode_e dec_w;

    assign open_w = bus_rst_i & usr_sync_i;
    assign dec_w  = decode_pattern(pat_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q.mode  <= MODE_CONV;
            cap_q.valid <= 1'b0;
        end else begin
            if (open_w) cap_q.mode <= dec_w;
            cap_q.valid <= ~usr_sync_i;
        end
    end

    assign cap_o = cap_q;

    // R6: a closed capture keeps its mode
    a_r6_closed_hold: assert property (@(posedge clk) disable iff (rst)
        (!bus_rst_i || !usr_sync_i) |=> $stable(cap_o.mode))
        else $error("a_r6_closed_hold");

    // R2: valid follows the closing of the capture by one clock
    a_r2_valid_after_close: assert property (@(posedge clk) disable iff (rst)
        $fell(usr_sync_i) |=> cap_o.valid)
        else $error("a_r2_valid_after_close");

    // R3: reserved encoding never appears
    a_r3_no_reserved: assert property (@(posedge clk) disable iff (rst)
        cap_o.mode != MODE_RSVD)
        else $error("a_r3_no_reserved");

endmodule

// File: rtl/bmd_gate.sv
module bmd_gate
    import bmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      usr_sync_i,
    input  capture_t  cap_i,
    input  bus_mode_e sup_i,
    output logic      rtr_o,
    output logic      lrst_o
);

    assign rtr_o  = (cap_i.mode != sup_i);
    assign lrst_o = rst | usr_sync_i | rtr_o;

    // R1: reset drives the gated local reset on the next edge
    a_r1_reset_gates: assert property (@(posedge clk)
        rst |=> lrst_o)
        else $error("a_r1_reset_gates");

    // R7: a valid request keeps the device logic in reset
    a_r7_request_holds: assert property (@(posedge clk) disable iff (rst)
        (cap_i.valid && rtr_o) |-> lrst_o)
        else $error("a_r7_request_holds");

endmodule

// File: rtl/bmd_top.sv
module bmd_top
    import bmd_pkg::*;
#(
    parameter logic [1:0] SUPPORTED   = 2'b10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_rst_i,
    input  logic       usr_rst_i,
    input  logic [2:0] pat_i,
    input  logic       frc_en_i,
    input  logic [1:0] frc_mode_i,
    output logic [1:0] det_mode_o,
    output logic       rtr_o,
    output logic       vld_o,
    output logic       lrst_o
);

    logic      usr_sync;
    capture_t  cap;
    bus_mode_e sup;

    assign sup = resolve_support(frc_en_i, frc_mode_i, SUPPORTED);

    bmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (usr_rst_i),
        .q_o (usr_sync)
    );

    bmd_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .bus_rst_i  (bus_rst_i),
        .usr_sync_i (usr_sync),
        .pat_i      (pat_i),
        .cap_o      (cap)
    );

    bmd_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .usr_sync_i (usr_sync),
        .cap_i      (cap),
        .sup_i      (sup),
        .rtr_o      (rtr_o),
        .lrst_o     (lrst_o)
    );

    assign det_mode_o = cap.mode;
    assign vld_o      = cap.valid;

    // R5: once valid, the request does not move unless support inputs move
    a_r5_stable_when_valid: assert property (@(posedge clk) disable iff (rst)
        (vld_o && $past(vld_o) && $stable(frc_en_i) && $stable(frc_mode_i))
            |-> $stable(rtr_o))
        else $error("a_r5_stable_when_valid");

endmodule

// File: tb/sim_bmd_top.sv
module sim_bmd_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_rst_i;
    logic       usr_rst_i;
    logic [2:0] pat_i;
    logic       frc_en_i;
    logic [1:0] frc_mode_i;
    logic [1:0] det_mode_o;
    logic       rtr_o;
    logic       vld_o;
    logic       lrst_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bmd_top u0 (
        .clk        (clk),
        .rst        (rst),
        .bus_rst_i  (bus_rst_i),
        .usr_rst_i  (usr_rst_i),
        .pat_i      (pat_i),
        .frc_en_i   (frc_en_i),
        .frc_mode_i (frc_mode_i),
        .det_mode_o (det_mode_o),
        .rtr_o      (rtr_o),
        .vld_o      (vld_o),
        .lrst_o     (lrst_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_mode(input int p);
        int lo;
        lo = p % 4;
        if (p < 4) return 0;
        if (lo == 1) return 1;
        if (lo == 2) return 2;
        return 0;
    endfunction

    function automatic int exp_sup(input int fen, input int fm);
        int s;
        s = fen ? fm : 2;
        return (s == 3) ? 0 : s;
    endfunction

    task automatic run_case(input int p, input int fen, input int fm);
        int m;
        int s;
        m = exp_mode(p);
        s = exp_sup(fen, fm);
        @(negedge clk);
        bus_rst_i  = 1'b1;
        usr_rst_i  = 1'b1;
        pat_i      = 3'(p);
        frc_en_i   = 1'(fen);
        frc_mode_i = 2'(fm);
        repeat (3) @(negedge clk);
        check("R5 open rtr", int'(rtr_o), int'(m != s));
        check("R2 vld while reset", int'(vld_o), 0);
        check("R7 lrst while reset", int'(lrst_o), 1);
        // transient on top pattern bit, visible after one edge
        pat_i = 3'(p ^ 4);
        @(negedge clk);
        check("R5 transient", int'(rtr_o), int'(exp_mode(p ^ 4) != s));
        pat_i = 3'(p);
        @(negedge clk);
        bus_rst_i = 1'b0;
        @(negedge clk);
        usr_rst_i = 1'b0;
        @(negedge clk);
        check("R2 vld edge1", int'(vld_o), 0);
        @(negedge clk);
        check("R2 vld edge2", int'(vld_o), 0);
        @(negedge clk);
        check("R2 vld edge3", int'(vld_o), 1);
        check("R3 decode", int'(det_mode_o), m);
        check("R4 rtr vs support", int'(rtr_o), int'(m != s));
        check("R7 lrst gating", int'(lrst_o), int'(m != s));
        pat_i = ~3'(p);
        repeat (2) @(negedge clk);
        check("R6 closed ignore", int'(det_mode_o), m);
    endtask

    initial begin
        rst = 1'b1; bus_rst_i = 1'b0; usr_rst_i = 1'b1;
        pat_i = 3'b110; frc_en_i = 1'b0; frc_mode_i = 2'b00;
        repeat (3) @(negedge clk);
        check("R1 det_mode", int'(det_mode_o), 0);
        check("R1 vld", int'(vld_o), 0);
        check("R1 lrst", int'(lrst_o), 1);
        rst = 1'b0;

        for (int fen = 0; fen < 2; fen++)
            for (int fm = 0; fm < 4; fm++)
                for (int p = 0; p < 8; p++)
                    run_case(p, fen, fm);

        // R8: mismatch then matching bus reset, no power-on reset
        run_case(0, 0, 0);
        check("R8 mismatch set", int'(rtr_o), 1);
        run_case(6, 0, 0);
        check("R8 rtr cleared", int'(rtr_o), 0);
        check("R8 lrst released", int'(lrst_o), 0);

        // R6: user reset alone opens nothing without bus reset
        @(negedge clk);
        usr_rst_i = 1'b1;
        bus_rst_i = 1'b0;
        pat_i = 3'b000;
        repeat (4) @(negedge clk);
        check("R6 usr only", int'(det_mode_o), 2);
        check("R7 usr reset gates", int'(lrst_o), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule